// File: doc/BRIEF.md
# Page-Erasable NOR Flash Controller

This block fronts a small on-chip NOR-style non-volatile array and a 64-word user configuration area behind one 32-bit register bus. Software controls it through a configuration register that holds two enable bits, a status register that always reports ready, and command registers that erase a single page, the whole array, or just the user area. Every operation completes in the cycle it is issued.

Programming follows NOR rules. A write to a flash word can only clear bits, because the stored word is ANDed with the new data. Restoring ones takes an erase. Page erase accepts a byte address and drops its in-page offset. Whole-array and user-area erase fire only on a key value. The flash array keeps its contents through reset. The configuration register and the user area return to their reset values.

The bus takes one word per access, and `addr_i` is a word address. The top two address bits select the region: 00 is flash, 01 is the user area, 10 is the controller registers and 11 is unmapped. Read data is registered and appears in the cycle after `re_i`.

Top module: `flash_ctrl`

## Requirements
- R1: Read data appears on `rdata_o` in the cycle after `re_i` and is zero when no read was issued. The region is chosen by `addr_i[8:7]`. Flash word index is `addr_i[6:0]`, and indices at or above FLASH_WORDS read zero and ignore writes. User word index is `addr_i[6:0]`, and indices 64 to 127 read zero and ignore writes.
- R2: A write to the configuration register (controller offset 1) stores `wdata_i & 32'h3`, and a read returns the stored value. Bit 0 is write-enable and bit 1 is erase-enable.
- R3: A flash word write with write-enable clear leaves the array unchanged.
- R4: A flash word write with write-enable set stores old word AND new data.
- R5: A write to either page-erase register (controller offsets 2 and 3) with erase-enable set takes the data as a byte address. The low log2(PAGE_WORDS*4) bits are cleared. If the result is at most FLASH_WORDS*4 - PAGE_WORDS*4, every word of that page becomes 32'hFFFFFFFF and all other pages are unchanged.
- R6: A page erase whose page start lies past the last full page is ignored. A page erase issued with erase-enable clear is also ignored.
- R7: A write of 1 to the erase-all register (controller offset 4) with erase-enable set sets every flash word and every user word to all ones. Any other value, or a clear erase-enable bit, changes nothing.
- R8: A write of 1 to the user-erase register (controller offset 5) sets all 64 user words to all ones whatever the configuration. Any other value changes nothing.
- R9: The status register (controller offset 0) always reads 1. Writes to it are ignored.
- R10: Reset sets the configuration register to 0 and every user word to all ones, and leaves flash contents unchanged.
- R11: An access to controller offsets 6 to 127, or to region 11, reads zero, changes nothing, and pulses `err_o` for one cycle in the cycle after the access. Defined registers, including reads of the command registers (which read zero), never raise `err_o`.
- R12: A write to a user word stores the data as given. There is no enable gating and no AND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address of the access |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse on an unmapped access |

## Verification
The bench programs every flash word twice, with two unrelated patterns. A design that overwrote the word instead of ANDing it would show the second pattern rather than the intersection.

It erases the pages one at a time over a zeroed array and reads the whole array after each erase. This exposes an erase that hits the wrong page or a neighbouring page, and an address mask that keeps offset bits. The highest valid byte address is used, together with addresses just past the array and near the top of the 32-bit range.

Each erase command is also tried with a wrong key and with erase-enable clear. A gating mistake would show up as wiped user or flash data. A reset in the middle of the run checks that flash survives reset while the user area and configuration do not.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  typedef enum logic [1:0] {
    RGN_FLASH = 2'd0,
    RGN_USER  = 2'd1,
    RGN_CTRL  = 2'd2,
    RGN_NONE  = 2'd3
  } region_e;

  localparam int unsigned OFF_STATUS     = 0;
  localparam int unsigned OFF_CONFIG     = 1;
  localparam int unsigned OFF_PG_ERASE_A = 2;
  localparam int unsigned OFF_PG_ERASE_B = 3;
  localparam int unsigned OFF_ERASE_ALL  = 4;
  localparam int unsigned OFF_ERASE_USER = 5;

  localparam int unsigned USER_WORDS = 64;
  localparam logic [31:0] CFG_MASK   = 32'h0000_0003;
  localparam logic [31:0] ERASE_KEY  = 32'h0000_0001;
  localparam logic [31:0] STATUS_VAL = 32'h0000_0001;

  typedef struct packed {
    logic cfg_wr;
    logic pg_erase;
    logic erase_all;
    logic erase_user;
    logic undef;
  } ctl_cmd_t;
endpackage

// File: rtl/flash_ctrl_decode.sv
module flash_ctrl_decode
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [31:0]       wdata_i,
  output region_e           region_o,
  output logic [ADDR_W-3:0] idx_o,
  output ctl_cmd_t          cmd_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic in_ctrl;
  logic ctl_wr;

  always_comb begin
    region_o = region_e'(addr_i[ADDR_W-1 -: 2]);
    idx_o    = addr_i[IDX_W-1:0];
    in_ctrl  = (region_o == RGN_CTRL);
    ctl_wr   = in_ctrl & we_i;
    cmd_o.cfg_wr     = ctl_wr & (idx_o == IDX_W'(OFF_CONFIG));
    cmd_o.pg_erase   = ctl_wr & ((idx_o == IDX_W'(OFF_PG_ERASE_A)) |
                                 (idx_o == IDX_W'(OFF_PG_ERASE_B)));
    cmd_o.erase_all  = ctl_wr & (idx_o == IDX_W'(OFF_ERASE_ALL)) & (wdata_i == ERASE_KEY);
    cmd_o.erase_user = ctl_wr & (idx_o == IDX_W'(OFF_ERASE_USER)) & (wdata_i == ERASE_KEY);
    cmd_o.undef      = (we_i | re_i) &
                       ((region_o == RGN_NONE) | (in_ctrl & (idx_o > IDX_W'(OFF_ERASE_USER))));
  end
endmodule

// File: rtl/flash_ctrl_array.sv
module flash_ctrl_array #(
  parameter int unsigned WORDS      = 64,
  parameter int unsigned PAGE_WORDS = 8,
  parameter int unsigned IDX_W      = 7
) (
  input  logic             clk_i,
  input  logic             prog_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [31:0]      prog_data_i,
  input  logic             pg_erase_i,
  input  logic [31:0]      pg_addr_i,
  input  logic             erase_all_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_data_o
);
  localparam int unsigned PAGE_BYTES = PAGE_WORDS * 4;
  localparam int unsigned PB_SH      = $clog2(PAGE_BYTES);
  localparam int unsigned WI         = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [31:0] OFF_MASK   = 32'(PAGE_BYTES - 1);
  localparam logic [31:0] LAST_START = 32'(WORDS * 4 - PAGE_BYTES);

  logic [WORDS-1:0][31:0] words;
  logic [31:0] pg_base;
  logic [31:0] pg_num;
  logic        pg_ok;

  always_comb begin
    pg_base = pg_addr_i & ~OFF_MASK;
    pg_num  = pg_base >> PB_SH;
    pg_ok   = pg_erase_i & (pg_base <= LAST_START);
  end

  // No reset: contents survive reset like real non-volatile cells.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int unsigned PG = w / PAGE_WORDS;
    logic [31:0] word_q;
    always_ff @(posedge clk_i) begin
      if (erase_all_i || (pg_ok && pg_num == 32'(PG))) word_q <= '1;
      else if (prog_i && prog_idx_i == IDX_W'(w))     word_q <= word_q & prog_data_i;
    end
    assign words[w] = word_q;
  end

  assign rd_data_o = (32'(rd_idx_i) < WORDS) ? words[rd_idx_i[WI-1:0]] : '0;
endmodule

// File: rtl/flash_ctrl_user.sv
module flash_ctrl_user
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      data_i,
  input  logic             clear_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_data_o
);
  localparam int unsigned UI = $clog2(USER_WORDS);

  logic [USER_WORDS-1:0][31:0] words;

  for (genvar w = 0; w < USER_WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q <= '1;
      else if (clear_i)                         word_q <= '1;
      else if (wr_i && idx_i == IDX_W'(w))      word_q <= data_i;
    end
    assign words[w] = word_q;
  end

  assign rd_data_o = (32'(rd_idx_i) < USER_WORDS) ? words[rd_idx_i[UI-1:0]] : '0;
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned FLASH_WORDS = 64,
  parameter int unsigned PAGE_WORDS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  region_e          region;
  logic [IDX_W-1:0] idx;
  ctl_cmd_t         cmd;
  logic [31:0]      cfg_q;
  logic [31:0]      flash_rd, user_rd, rd_mux, rdata_q;
  logic             err_q;
  logic             wen, een;

  flash_ctrl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i, .we_i, .re_i, .wdata_i,
    .region_o(region), .idx_o(idx), .cmd_o(cmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= '0;
    else if (cmd.cfg_wr) cfg_q <= wdata_i & CFG_MASK;
  end

  assign wen = cfg_q[0];
  assign een = cfg_q[1];

  flash_ctrl_array #(
    .WORDS(FLASH_WORDS), .PAGE_WORDS(PAGE_WORDS), .IDX_W(IDX_W)
  ) u_array (
    .clk_i,
    .prog_i     (we_i & (region == RGN_FLASH) & wen),
    .prog_idx_i (idx),
    .prog_data_i(wdata_i),
    .pg_erase_i (cmd.pg_erase & een),
    .pg_addr_i  (wdata_i),
    .erase_all_i(cmd.erase_all & een),
    .rd_idx_i   (idx),
    .rd_data_o  (flash_rd)
  );

  flash_ctrl_user #(.IDX_W(IDX_W)) u_user (
    .clk_i, .rst_ni,
    .wr_i     (we_i & (region == RGN_USER)),
    .idx_i    (idx),
    .data_i   (wdata_i),
    .clear_i  (cmd.erase_user | (cmd.erase_all & een)),
    .rd_idx_i (idx),
    .rd_data_o(user_rd)
  );

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RGN_FLASH: rd_mux = flash_rd;
      RGN_USER:  rd_mux = user_rd;
      RGN_CTRL: begin
        if (idx == IDX_W'(OFF_STATUS))      rd_mux = STATUS_VAL;
        else if (idx == IDX_W'(OFF_CONFIG)) rd_mux = cfg_q;
      end
      RGN_NONE:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= re_i ? rd_mux : '0;
      err_q   <= cmd.undef;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk
  import flash_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic [31:0]       cfg_i,
  input logic [31:0]       flash0_i,
  input logic [31:0]       user0_i,
  input logic [31:0]       user_last_i
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'((2 << IDX_W) + OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'((2 << IDX_W) + OFF_CONFIG);
  localparam logic [ADDR_W-1:0] A_EUSER  = ADDR_W'((2 << IDX_W) + OFF_ERASE_USER);

  p_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && addr_i == A_STATUS |=> rdata_o == STATUS_VAL);

  p_cfg_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_CFG |=> cfg_i == ($past(wdata_i) & CFG_MASK));

  p_flash_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == '0 && !cfg_i[0] |=> $stable(flash0_i));

  p_flash_and_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == '0 && cfg_i[0] |=> flash0_i == ($past(flash0_i) & $past(wdata_i)));

  p_user_erase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_EUSER && wdata_i == ERASE_KEY |=> user0_i == '1 && user_last_i == '1);

  p_err_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i || re_i) && addr_i[ADDR_W-1 -: 2] == 2'b11 |=> err_o);

  p_err_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(we_i || re_i));
endmodule

bind flash_ctrl flash_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .re_i, .wdata_i, .rdata_o, .err_o,
  .cfg_i      (cfg_q),
  .flash0_i   (u_array.words[0]),
  .user0_i    (u_user.words[0]),
  .user_last_i(u_user.words[63])
);

// File: tb/tb_flash_ctrl.sv
module tb_flash_ctrl;
  localparam int AW = 9;
  localparam int FW = 64;
  localparam int PW = 8;
  localparam int NP = FW / PW;
  localparam logic [AW-1:0] A_USER = 9'h080;
  localparam logic [AW-1:0] A_CTL  = 9'h100;
  localparam logic [AW-1:0] A_NONE = 9'h180;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic we = 0, re = 0;
  logic [31:0] wdata = '0, rdata;
  logic err;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [31:0] m_flash [FW];
  logic [31:0] m_user [64];
  logic [31:0] m_cfg;

  always #5 clk = ~clk;

  flash_ctrl #(.ADDR_W(AW), .FLASH_WORDS(FW), .PAGE_WORDS(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err)
  );

  task automatic acc(input logic [AW-1:0] a, input logic w, input logic r,
                     input logic [31:0] d, input logic [31:0] exp,
                     input logic exp_err, input string tag);
    addr = a; we = w; re = r; wdata = d;
    @(negedge clk);
    we = 0; re = 0;
    if (r) begin
      checks++;
      if (rdata !== exp) begin
        errs++;
        $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, a, rdata, exp);
      end
    end
    checks++;
    if (err !== exp_err) begin
      errs++;
      $display("FAIL %s err_o addr=%h actual=%b expected=%b", tag, a, err, exp_err);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    acc(a, 1'b1, 1'b0, d, '0, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    acc(a, 1'b0, 1'b1, '0, exp, 1'b0, tag);
  endtask

  task automatic set_cfg(input logic [31:0] d);
    wr(A_CTL + 9'd1, d, "R2");
    m_cfg = d & 32'h3;
  endtask

  task automatic flash_wr(input int i, input logic [31:0] d, input string tag);
    wr(9'(i), d, tag);
    if (m_cfg[0]) m_flash[i] = m_flash[i] & d;
  endtask

  task automatic chk_flash(input string tag);
    for (int i = 0; i < FW; i++) rd(9'(i), m_flash[i], tag);
  endtask

  task automatic chk_user(input string tag);
    for (int i = 0; i < 64; i++) rd(A_USER + 9'(i), m_user[i], tag);
  endtask

  task automatic fill_user(input logic [31:0] seed);
    for (int i = 0; i < 64; i++) begin
      m_user[i] = seed ^ (32'(i) * 32'h0101_0307);
      wr(A_USER + 9'(i), m_user[i], "R12");
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_user[i] = '1;
    m_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10, R9 reset values
    rd(A_CTL + 9'd1, 32'h0, "R10");
    rd(A_CTL + 9'd0, 32'h1, "R9");
    chk_user("R10");
    wr(A_CTL + 9'd0, 32'h0, "R9");
    rd(A_CTL + 9'd0, 32'h1, "R9");

    // R2 masking
    wr(A_CTL + 9'd1, 32'hFFFF_FFFF, "R2");
    rd(A_CTL + 9'd1, 32'h3, "R2");
    wr(A_CTL + 9'd1, 32'hABCD_0005, "R2");
    rd(A_CTL + 9'd1, 32'h1, "R2");
    set_cfg(32'h0);
    rd(A_CTL + 9'd1, 32'h0, "R2");

    // R12 user writes, R7 gating
    fill_user(32'h5A3C_96E1);
    chk_user("R12");
    wr(A_CTL + 9'd4, 32'h1, "R7");
    chk_user("R7");
    set_cfg(32'h2);
    wr(A_CTL + 9'd4, 32'h2, "R7");
    chk_user("R7");
    wr(A_CTL + 9'd4, 32'h1, "R7");
    for (int i = 0; i < 64; i++) m_user[i] = '1;
    for (int i = 0; i < FW; i++) m_flash[i] = '1;
    chk_user("R7");
    chk_flash("R7");

    // R4 program twice
    set_cfg(32'h1);
    for (int i = 0; i < FW; i++) flash_wr(i, 32'hC3A5_0F96 ^ (32'(i) * 32'h0103_0507), "R4");
    chk_flash("R4");
    for (int i = 0; i < FW; i++) flash_wr(i, ~(32'(i) * 32'h9E37_79B9), "R4");
    chk_flash("R4");

    // R3 write disabled
    set_cfg(32'h0);
    for (int i = 0; i < FW; i++) flash_wr(i, 32'h0, "R3");
    chk_flash("R3");
    set_cfg(32'h2);
    for (int i = 0; i < FW; i++) flash_wr(i, 32'h0, "R3");
    chk_flash("R3");

    // zero the array for page tests
    set_cfg(32'h1);
    for (int i = 0; i < FW; i++) flash_wr(i, 32'h0, "R4");
    chk_flash("R4");

    // R6 ignored page erases
    wr(A_CTL + 9'd2, 32'h0, "R6");
    wr(A_CTL + 9'd3, 32'h20, "R6");
    set_cfg(32'h2);
    wr(A_CTL + 9'd2, 32'(FW * 4), "R6");
    wr(A_CTL + 9'd3, 32'(FW * 4 + 5), "R6");
    wr(A_CTL + 9'd2, 32'hFFFF_FFE0, "R6");
    chk_flash("R6");

    // R5 sweep over pages, both registers, offset masked
    for (int p = 0; p < NP; p++) begin
      int off;
      off = (p == NP - 1) ? PW * 4 - 1 : (p * 7) % (PW * 4);
      wr(A_CTL + ((p % 2 == 0) ? 9'd2 : 9'd3), 32'(p * PW * 4 + off), "R5");
      for (int w = 0; w < PW; w++) m_flash[p * PW + w] = '1;
      chk_flash("R5");
    end

    // R8 user erase
    set_cfg(32'h0);
    fill_user(32'h1234_8765);
    wr(A_CTL + 9'd5, 32'h7, "R8");
    chk_user("R8");
    wr(A_CTL + 9'd5, 32'h1, "R8");
    for (int i = 0; i < 64; i++) m_user[i] = '1;
    chk_user("R8");

    // R11 unmapped accesses, R1 out-of-range indices
    fill_user(32'h0F0F_3333);
    set_cfg(32'h1);
    acc(A_CTL + 9'd6, 1'b0, 1'b1, '0, 32'h0, 1'b1, "R11");
    acc(A_CTL + 9'd127, 1'b0, 1'b1, '0, 32'h0, 1'b1, "R11");
    acc(A_NONE + 9'd3, 1'b0, 1'b1, '0, 32'h0, 1'b1, "R11");
    acc(A_NONE, 1'b1, 1'b0, 32'h1, '0, 1'b1, "R11");
    acc(A_CTL + 9'd6, 1'b1, 1'b0, 32'h3, '0, 1'b1, "R11");
    rd(A_CTL + 9'd1, 32'h1, "R11");
    rd(A_CTL + 9'd2, 32'h0, "R11");
    rd(A_CTL + 9'd4, 32'h0, "R11");
    rd(A_CTL + 9'd5, 32'h0, "R11");
    wr(A_USER + 9'd64, 32'h0, "R1");
    rd(A_USER + 9'd64, 32'h0, "R1");
    rd(A_USER + 9'd127, 32'h0, "R1");
    wr(9'd64, 32'h0, "R1");
    rd(9'd64, 32'h0, "R1");
    chk_user("R1");
    chk_flash("R1");
    addr = 9'd0; re = 0;
    @(negedge clk);
    checks++;
    if (rdata !== 32'h0) begin
      errs++;
      $display("FAIL R1 idle rdata actual=%h expected=%h", rdata, 32'h0);
    end

    // R10 retention across reset
    for (int i = 0; i < FW; i += 5) flash_wr(i, 32'h0000_FFFF, "R4");
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_cfg = '0;
    for (int i = 0; i < 64; i++) m_user[i] = '1;
    rd(A_CTL + 9'd1, 32'h0, "R10");
    chk_user("R10");
    chk_flash("R10");

    done = 1;
    summary();
  end
endmodule